// File: doc/BRIEF.md
# Video Memory Block-Copy DMA Engine

The engine copies a block of bytes from anywhere in a 16-bit system address space into an 8 KiB window that sits at offset 0x8000 of that space. Software programs it through five byte-wide registers on a small register port: a source address split into high and low bytes, a destination offset split into high and low bytes, and a control register. Writing the control register starts the copy at once. The block size is a count of 16-byte units minus one.

During a copy the engine drives a simple memory master port. For each byte it makes one read access and then one write access. Each access holds its request until the memory returns ready. The engine raises a busy output for the whole copy. When the last byte is written it sets bit 7 of the control register, so software can poll that bit to see that the copy is done.

The sequencer has three states. IDLE waits for a start. READ requests the source byte. WRITE stores that byte at the destination. The transitions are as follows. In IDLE, an accepted start goes to READ. In READ, ready goes to WRITE and captures the data. In WRITE, ready goes back to READ if more bytes remain, or to IDLE after the final byte. In both READ and WRITE, a cycle without ready stays in the same state.

Top module: `vid_copy_dma`

## Requirements
- R1: After reset every register reads 0x00, busy is low and mem_req is low. Register selector codes: 0 source high, 1 source low, 2 destination high, 3 destination low, 4 control. A register write takes effect at the clock edge on which reg_wr is high, and reg_rdata shows the selected register combinationally.
- R2: The source high register stores and reads back all 8 bits. The source low register keeps only bits 7:4, with bits 3:0 reading as zero, so the source address is 16-byte aligned.
- R3: The destination high register keeps only bits 4:0 and the destination low register keeps only bits 7:4. Together they form a 13-bit offset {high[4:0], low}.
- R4: A control-register write while idle starts a copy of (N+1)*16 bytes, where N is bits 6:0 of the written value. Exactly that many read accesses and that many write accesses are made.
- R5: Byte i is read from source+i and then written to 0x8000+offset+i. Bytes go in increasing i, and each read is followed directly by its write.
- R6: Address arithmetic wraps modulo 2^16. For example, a source of 0xFFF0 continues at 0x0000.
- R7: The data of each write equals the data returned by the preceding read.
- R8: While a copy runs, the control register reads {0, N}. After the final write it reads {1, N}.
- R9: Busy rises in the cycle after an accepted start and falls after the last write handshake. mem_req is high only while busy. A control write during a copy is ignored: it launches nothing and changes no status.
- R10: While mem_req is high and mem_ready is low, mem_req, mem_we, mem_addr and mem_wdata hold steady.
- R11: With mem_ready returned in the same cycle as every request, a copy of B bytes keeps busy high for exactly 2B cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selector |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| busy | output | 1 | Copy in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | 16 | Memory access address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Access accepted this cycle |

## Verification
A register write is visible on readback in the cycle after its strobe. An accepted start raises busy in that same following cycle. With zero-wait memory, B bytes then take 2B busy cycles, and the bench counts busy at falling edges from the first cycle after the write.

Every access completes at the rising edge where request and ready are both high. The bench's memory model raises ready at the preceding falling edge and pops the expected access from the scoreboard at that same moment, so address, direction and data are compared exactly at the edge the access happens. With waits of zero to two cycles, the bench also confirms that the access stays parked in place until ready arrives.

The status register is read one cycle into the copy and again once busy has fallen.

// File: rtl/vcd_pkg.sv
package vcd_pkg;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_SRC_HI = 3'd0;
    localparam logic [SEL_W-1:0] SEL_SRC_LO = 3'd1;
    localparam logic [SEL_W-1:0] SEL_DST_HI = 3'd2;
    localparam logic [SEL_W-1:0] SEL_DST_LO = 3'd3;
    localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/vcd_regs.sv
module vcd_regs
    import vcd_pkg::*;
#(
    parameter int UNIT_LG = 4,
    parameter int WIN_W   = 13,
    parameter int LEN_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               busy,
    input  logic               xfer_done,
    output logic               start,
    output logic [15:0]        src_base,
    output logic [WIN_W-1:0]   dst_off,
    output logic [LEN_W-1:0]   len_units
);

    localparam logic [7:0] LO_MASK  = 8'(8'hFF << UNIT_LG);
    localparam int         DHI_W    = WIN_W - 8;
    localparam logic [7:0] DHI_MASK = 8'((1 << DHI_W) - 1);

    logic [7:0]       src_hi_q, src_lo_q, dst_hi_q, dst_lo_q;
    logic             done_q;
    logic [LEN_W-1:0] len_q;
    logic [7:0]       ctrl_view;

    assign start = reg_wr && (reg_sel == SEL_CTRL) && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_hi_q <= '0;
            src_lo_q <= '0;
            dst_hi_q <= '0;
            dst_lo_q <= '0;
            done_q   <= 1'b0;
            len_q    <= '0;
        end else begin
            if (reg_wr) begin
                unique case (reg_sel)
                    SEL_SRC_HI: src_hi_q <= reg_wdata;
                    SEL_SRC_LO: src_lo_q <= reg_wdata & LO_MASK;
                    SEL_DST_HI: dst_hi_q <= reg_wdata & DHI_MASK;
                    SEL_DST_LO: dst_lo_q <= reg_wdata & LO_MASK;
                    default: ;
                endcase
            end
            if (start) begin
                len_q  <= reg_wdata[LEN_W-1:0];
                done_q <= 1'b0;
            end else if (xfer_done) begin
                done_q <= 1'b1;
            end
        end
    end

    always_comb begin
        ctrl_view              = '0;
        ctrl_view[LEN_W-1:0]   = len_q;
        ctrl_view[7]           = done_q;
    end

    always_comb begin
        unique case (reg_sel)
            SEL_SRC_HI: reg_rdata = src_hi_q;
            SEL_SRC_LO: reg_rdata = src_lo_q;
            SEL_DST_HI: reg_rdata = dst_hi_q;
            SEL_DST_LO: reg_rdata = dst_lo_q;
            SEL_CTRL:   reg_rdata = ctrl_view;
            default:    reg_rdata = 8'h00;
        endcase
    end

    assign src_base  = {src_hi_q, src_lo_q};
    assign dst_off   = {dst_hi_q[DHI_W-1:0], dst_lo_q};
    assign len_units = len_q;

endmodule

// File: rtl/vcd_addr.sv
module vcd_addr #(
    parameter int          ADDR_W   = 16,
    parameter int          WIN_W    = 13,
    parameter int          IDX_W    = 11,
    parameter logic [15:0] WIN_BASE = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       src_base,
    input  logic [WIN_W-1:0]  dst_off,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr
);

    logic [ADDR_W-1:0] src_q, dst_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (start) begin
            src_q <= ADDR_W'(src_base);
            dst_q <= ADDR_W'(WIN_BASE) + ADDR_W'(dst_off);
        end
    end

    assign rd_addr = src_q + ADDR_W'(idx);
    assign wr_addr = dst_q + ADDR_W'(idx);

endmodule

// File: rtl/vcd_seq.sv
module vcd_seq
    import vcd_pkg::*;
#(
    parameter int LEN_W   = 7,
    parameter int UNIT_LG = 4,
    parameter int DATA_W  = 8,
    parameter int IDX_W   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len_units,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] wr_data,
    output logic [IDX_W-1:0]  idx,
    output logic              busy,
    output logic              xfer_done
);

    seq_state_t        state, nxt;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] data_q;
    logic [IDX_W-1:0]  last_idx;
    logic              is_last;

    assign last_idx = {len_units, {UNIT_LG{1'b1}}};
    assign is_last  = (idx_q == last_idx);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start)     nxt = ST_READ;
            ST_READ:  if (mem_ready) nxt = ST_WRITE;
            ST_WRITE: if (mem_ready) nxt = is_last ? ST_IDLE : ST_READ;
            default:                 nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            data_q <= '0;
        end else begin
            if (state == ST_IDLE && start)
                idx_q <= '0;
            else if (state == ST_WRITE && mem_ready && !is_last)
                idx_q <= idx_q + 1'b1;
            if (state == ST_READ && mem_ready)
                data_q <= mem_rdata;
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        xfer_done = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_READ:  mem_req = 1'b1;
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                xfer_done = mem_ready && is_last;
            end
            default: ;
        endcase
    end

    assign busy    = (state != ST_IDLE);
    assign idx     = idx_q;
    assign wr_data = data_q;

endmodule

// File: rtl/vid_copy_dma.sv
module vid_copy_dma
    import vcd_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          UNIT_LG  = 4,
    parameter int          WIN_W    = 13,
    parameter int          LEN_W    = 7,
    parameter logic [15:0] WIN_BASE = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready
);

    localparam int IDX_W = LEN_W + UNIT_LG;

    logic              start, xfer_done;
    logic [15:0]       src_base;
    logic [WIN_W-1:0]  dst_off;
    logic [LEN_W-1:0]  len_units;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] rd_addr, wr_addr;

    vcd_regs #(.UNIT_LG(UNIT_LG), .WIN_W(WIN_W), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .xfer_done(xfer_done), .start(start), .src_base(src_base),
        .dst_off(dst_off), .len_units(len_units)
    );

    vcd_addr #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .IDX_W(IDX_W), .WIN_BASE(WIN_BASE)) u_addr (
        .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base),
        .dst_off(dst_off), .idx(idx), .rd_addr(rd_addr), .wr_addr(wr_addr)
    );

    vcd_seq #(.LEN_W(LEN_W), .UNIT_LG(UNIT_LG), .DATA_W(8), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .len_units(len_units),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .wr_data(mem_wdata), .idx(idx), .busy(busy),
        .xfer_done(xfer_done)
    );

    assign mem_addr = mem_we ? wr_addr : rd_addr;

endmodule

// File: rtl/vid_copy_dma_chk.sv
module vid_copy_dma_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_sel,
    input logic [7:0]        reg_rdata,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              mem_ready
);

    logic              rd_hs, wr_hs;
    logic              seen_rd, seen_wr;
    logic [ADDR_W-1:0] last_rd, last_wr;

    assign rd_hs = mem_req && mem_ready && !mem_we;
    assign wr_hs = mem_req && mem_ready && mem_we;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            seen_rd <= 1'b0;
            seen_wr <= 1'b0;
            last_rd <= '0;
            last_wr <= '0;
        end else begin
            if (rd_hs) begin seen_rd <= 1'b1; last_rd <= mem_addr; end
            if (wr_hs) begin seen_wr <= 1'b1; last_wr <= mem_addr; end
        end
    end

    // R10: a parked access keeps its request, direction, address and data
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

    // R5: every completed read is followed by its write
    a_r5_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hs |=> mem_req && mem_we);

    // R5: a completed write is followed by the next read or by idle
    a_r5_wr_then_next: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hs |=> (mem_req && !mem_we) || !busy);

    // R5: source addresses advance by one per byte
    a_r5_src_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hs && seen_rd |-> mem_addr == last_rd + 1'b1);

    // R5: destination addresses advance by one per byte
    a_r5_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hs && seen_wr |-> mem_addr == last_wr + 1'b1);

    // R9: requests only while busy
    a_r9_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R9: an accepted start raises busy
    a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_sel == 3'd4 && !busy |=> busy);

    // R8: completion flag is visible once busy drops
    a_r8_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && reg_sel == 3'd4 |-> reg_rdata[7]);

endmodule

bind vid_copy_dma vid_copy_dma_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/vid_copy_dma_tb.sv
module vid_copy_dma_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        busy, mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_ready = 1'b0;

    int total = 0;
    int bad = 0;
    int hs_count = 0;
    int wait_cnt = 0;
    int wait_mode = 0;
    string addr_tag = "R5";

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  data;
    } txn_t;
    txn_t exp_q[$];

    always #4 clk = ~clk;

    vid_copy_dma u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (wait_cnt >= ((wait_mode != 0) ? (hs_count % 3) : 0)) begin
                mem_ready = 1'b1;
                mem_rdata = pat(mem_addr);
                wait_cnt  = 0;
                hs_count++;
                if (exp_q.size() == 0) begin
                    check("R4 extra access", {15'd0, mem_we, mem_addr}, 32'hFFFF_FFFF);
                end else begin
                    txn_t e;
                    e = exp_q.pop_front();
                    check({addr_tag, " access dir/addr"}, {15'd0, mem_we, mem_addr}, {15'd0, e.we, e.addr});
                    if (e.we) check("R7 write data", {24'd0, mem_wdata}, {24'd0, e.data});
                end
            end else begin
                mem_ready = 1'b0;
                wait_cnt++;
            end
        end else begin
            mem_ready = 1'b0;
        end
    end

    task automatic reg_write(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] s, output logic [7:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    // driver: program addresses, push expected accesses, start the copy
    task automatic launch(input logic [15:0] src, input logic [12:0] dst, input logic [7:0] ctrl);
        int nbytes;
        logic [15:0] s0, d0;
        s0 = {src[15:4], 4'h0};
        d0 = 16'h8000 + {3'b000, dst[12:4], 4'h0};
        nbytes = (int'(ctrl[6:0]) + 1) * 16;
        for (int i = 0; i < nbytes; i++) begin
            logic [15:0] sa, da;
            sa = s0 + 16'(i);
            da = d0 + 16'(i);
            exp_q.push_back('{we: 1'b0, addr: sa, data: 8'h00});
            exp_q.push_back('{we: 1'b1, addr: da, data: pat(sa)});
        end
        reg_write(3'd0, src[15:8]);
        reg_write(3'd1, src[7:0]);
        reg_write(3'd2, {3'b000, dst[12:8]});
        reg_write(3'd3, dst[7:0]);
        reg_write(3'd4, ctrl);
    endtask

    task automatic wait_idle(output int cycles);
        cycles = 0;
        while (busy) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int cyc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 5; s++) begin
            reg_read(3'(s), rd);
            check("R1 reset register", {24'd0, rd}, 32'd0);
        end
        check("R1 busy after reset", {31'd0, busy}, 32'd0);
        check("R1 mem_req after reset", {31'd0, mem_req}, 32'd0);

        // R2 / R3 register masking
        reg_write(3'd0, 8'hAB);
        reg_write(3'd1, 8'h3C);
        reg_write(3'd2, 8'hFF);
        reg_write(3'd3, 8'h5A);
        reg_read(3'd0, rd); check("R2 source high readback", {24'd0, rd}, 32'hAB);
        reg_read(3'd1, rd); check("R2 source low mask", {24'd0, rd}, 32'h30);
        reg_read(3'd2, rd); check("R3 destination high mask", {24'd0, rd}, 32'h1F);
        reg_read(3'd3, rd); check("R3 destination low mask", {24'd0, rd}, 32'h50);
        check("R1 no copy from address writes", {31'd0, busy}, 32'd0);

        // 16-byte copy, zero wait: R4 R5 R7 R8 R11
        wait_mode = 0; addr_tag = "R5";
        launch(16'h1237, 13'h0547, 8'h80);
        check("R9 busy after start", {31'd0, busy}, 32'd1);
        reg_read(3'd4, rd); check("R8 status while busy", {24'd0, rd}, 32'h00);
        wait_idle(cyc);
        check("R11 busy cycles for 16 bytes", cyc, 32);
        check("R4 all accesses made", exp_q.size(), 0);
        reg_read(3'd4, rd); check("R8 status after done", {24'd0, rd}, 32'h80);

        // 48-byte copy with waits, ignored restart: R9 R10 R4
        wait_mode = 1;
        launch(16'h4000, 13'h1FF0, 8'h02);
        reg_read(3'd4, rd); check("R8 status while busy N=2", {24'd0, rd}, 32'h02);
        reg_write(3'd4, 8'h05);
        check("R9 still busy after ignored write", {31'd0, busy}, 32'd1);
        wait_idle(cyc);
        repeat (4) @(negedge clk);
        check("R9 no relaunch after ignored write", {31'd0, busy}, 32'd0);
        check("R4 exact access count with waits", exp_q.size(), 0);
        reg_read(3'd4, rd); check("R9 status unchanged by ignored write", {24'd0, rd}, 32'h82);

        // wrap-around of the source: R6
        wait_mode = 0; addr_tag = "R6";
        launch(16'hFFF0, 13'h0000, 8'h01);
        wait_idle(cyc);
        check("R11 busy cycles for 32 bytes", cyc, 64);
        check("R6 all wrapped accesses made", exp_q.size(), 0);
        reg_read(3'd4, rd); check("R8 status after wrap copy", {24'd0, rd}, 32'h81);

        // longest copy: R4 R11
        addr_tag = "R5";
        launch(16'h2000, 13'h1230, 8'h7F);
        wait_idle(cyc);
        check("R11 busy cycles for 2048 bytes", cyc, 4096);
        check("R4 longest copy complete", exp_q.size(), 0);
        reg_read(3'd4, rd); check("R8 status after longest copy", {24'd0, rd}, 32'hFF);

        repeat (4) @(negedge clk);
        check("R9 mem_req low when idle", {31'd0, mem_req}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule